// File: doc/BRIEF.md
# Cluster Cache Inclusion State Controller

This block holds the per-line coherence state of a second-level cache that is shared by a group of first-level caches. The first-level caches sit on a shared bus inside the group. The second-level cache talks to other groups over a separate bus. Each line carries three bits: a valid bit, a presence bit and a clean bit. The presence bit records that some first-level cache may hold a copy of the line. The clean bit records that the line matches memory.

The controller takes one operation per cycle. An operation is either an event from inside the group (a fill, a write-back, or a copy being made dirty), a transaction seen on the inter-group bus (read, write, invalidate), or a local eviction. Most operations update the line state in the cycle they are accepted. The controller sends an invalidate or purge command to the first level only when the presence bit says a copy may exist. While such a command waits for a grant from the group bus, the controller accepts no further operations. The line state changes only in the cycle the command is granted. A query port reads the state of any line at any time.

Top module: `cluster_incl_ctrl`

## Requirements

- R1: After reset, every line reads as Invalid, `l1_req` is 0 and `op_ready` is 1. `qry_state` is {valid, presence, clean}, with these encodings: Invalid = 000, CleanAlone = 101, CleanShared = 111, DirtyAlone = 100, DirtyShared = 110.
- R2: A first-level read fill (op 1) turns an Invalid line into CleanShared. On a valid line it sets the presence bit and keeps the clean bit.
- R3: A first-level write fill (op 2) makes the line DirtyShared, whatever its previous state.
- R4: A dirtying snoop (op 4) on a valid line clears the clean bit and sets the presence bit. It leaves an Invalid line Invalid.
- R5: A first-level write-back (op 3) on a valid line clears the clean bit. It clears the presence bit when `op_excl` is 1 and keeps it when `op_excl` is 0. It leaves an Invalid line Invalid.
- R6: On a CleanShared line, an inter-group read (op 5) raises no request and leaves the state unchanged. An inter-group write (op 6) or invalidate (op 7) raises a request with command 0 (invalidate), and the line becomes Invalid when the request is granted.
- R7: On a DirtyShared line, any inter-group operation (op 5, 6 or 7) raises a request with command 1 (purge). When the request is granted, the line becomes CleanShared after a read and Invalid after a write or invalidate.
- R8: On Invalid, CleanAlone and DirtyAlone lines, inter-group operations raise no request. A read turns DirtyAlone into CleanAlone and leaves the other two states unchanged. A write or invalidate makes the line Invalid.
- R9: An eviction (op 8) of a line whose presence bit is set raises a request: purge (1) if the line is dirty, invalidate (0) if it is clean. The line becomes Invalid on grant. A line whose presence bit is clear becomes Invalid at once, with no request.
- R10: While `l1_req` is high, it stays high and `l1_idx` and `l1_cmd` stay stable until `l1_gnt`. `op_ready` is 0 during this time, and operations presented then have no effect. The state change is written in the grant cycle.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present |
| op_code | input | 4 | Operation kind (codes listed in the requirements) |
| op_idx | input | IDX_W | Line index of the operation |
| op_excl | input | 1 | For write-back: the sole copy, or the other copies are invalidated |
| op_ready | output | 1 | An operation is accepted this cycle when high |
| l1_req | output | 1 | First-level command pending |
| l1_cmd | output | 1 | 0 = invalidate, 1 = purge |
| l1_idx | output | IDX_W | Line index of the pending command |
| l1_gnt | input | 1 | Group bus grants and completes the command |
| qry_idx | input | IDX_W | Line index to read |
| qry_state | output | 3 | {valid, presence, clean} of the queried line |

## Verification

The hardest situation to reach from the ports is a held first-level command that has not yet been granted. Only then can the bench check the back-pressure and the deferred state write. Reaching it takes two steps: a fill first sets the presence bit, and then an inter-group or eviction operation triggers the command. The stimulus table drives each command path and keeps the grant low for zero to two extra cycles before granting, while checking that the request, command and index do not move. Two directed tests then present an operation during the wait, and assert reset during the wait.

// File: rtl/cic_pkg.sv
package cic_pkg;

   typedef struct packed {
      logic vld;
      logic ib;
      logic cd;
   } line_t;

   typedef enum logic [3:0] {
      OP_IDLE   = 4'd0,
      OP_RFILL  = 4'd1,
      OP_WFILL  = 4'd2,
      OP_WBACK  = 4'd3,
      OP_DIRTY  = 4'd4,
      OP_XRD    = 4'd5,
      OP_XWR    = 4'd6,
      OP_XINV   = 4'd7,
      OP_EVICT  = 4'd8
   } op_t;

   localparam logic CMD_INVAL = 1'b0;
   localparam logic CMD_PURGE = 1'b1;

   localparam line_t LN_INV      = '{vld: 1'b0, ib: 1'b0, cd: 1'b0};
   localparam line_t LN_CLEAN_NI = '{vld: 1'b1, ib: 1'b0, cd: 1'b1};
   localparam line_t LN_CLEAN_I  = '{vld: 1'b1, ib: 1'b1, cd: 1'b1};
   localparam line_t LN_DIRTY_NI = '{vld: 1'b1, ib: 1'b0, cd: 1'b0};
   localparam line_t LN_DIRTY_I  = '{vld: 1'b1, ib: 1'b1, cd: 1'b0};

   function automatic logic is_inter(op_t op);
      return (op == OP_XRD) || (op == OP_XWR) || (op == OP_XINV);
   endfunction

endpackage

// File: rtl/cic_state_store.sv
module cic_state_store
   import cic_pkg::*;
#(
   parameter int LINES = 16,
   localparam int IDX_W = $clog2(LINES)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  line_t            wr_line,
   input  logic [IDX_W-1:0] rd_a_idx,
   output line_t            rd_a_line,
   input  logic [IDX_W-1:0] rd_b_idx,
   output line_t            rd_b_line
);

   line_t lines_q [LINES];

   generate
      for (genvar g = 0; g < LINES; g++) begin : g_line
         always_ff @(posedge clk) begin
            if (!rst_n)
               lines_q[g] <= LN_INV;
            else if (wr_en && (wr_idx == IDX_W'(g)))
               lines_q[g] <= wr_line;
         end

         AST_INVALID_HAS_NO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
            !lines_q[g].vld |-> (!lines_q[g].ib && !lines_q[g].cd)); // R1
      end
   endgenerate

   assign rd_a_line = lines_q[rd_a_idx];
   assign rd_b_line = lines_q[rd_b_idx];

endmodule

// File: rtl/cic_next_state.sv
module cic_next_state
   import cic_pkg::*;
(
   input  line_t cur,
   input  op_t   op,
   input  logic  excl,
   output line_t nxt,
   output logic  need_l1,
   output logic  l1_kind
);

   always_comb begin
      nxt     = cur;
      need_l1 = 1'b0;
      l1_kind = CMD_INVAL;
      unique case (op)
         OP_RFILL: begin
            if (!cur.vld) nxt = LN_CLEAN_I;
            else          nxt.ib = 1'b1;
         end
         OP_WFILL: nxt = LN_DIRTY_I;
         OP_WBACK: begin
            if (cur.vld) begin
               nxt.cd = 1'b0;
               if (excl) nxt.ib = 1'b0;
            end
         end
         OP_DIRTY: begin
            if (cur.vld) begin
               nxt.cd = 1'b0;
               nxt.ib = 1'b1;
            end
         end
         OP_XRD, OP_XWR, OP_XINV: begin
            if (!cur.vld) begin
               nxt = LN_INV;
            end else if (op == OP_XRD) begin
               nxt.cd = 1'b1;
               if (cur.ib && !cur.cd) begin
                  need_l1 = 1'b1;
                  l1_kind = CMD_PURGE;
               end
            end else begin
               nxt = LN_INV;
               if (cur.ib) begin
                  need_l1 = 1'b1;
                  l1_kind = cur.cd ? CMD_INVAL : CMD_PURGE;
               end
            end
         end
         OP_EVICT: begin
            nxt = LN_INV;
            if (cur.vld && cur.ib) begin
               need_l1 = 1'b1;
               l1_kind = cur.cd ? CMD_INVAL : CMD_PURGE;
            end
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/cic_l1_cmd_hold.sv
module cic_l1_cmd_hold
   import cic_pkg::*;
#(
   parameter int LINES = 16,
   localparam int IDX_W = $clog2(LINES)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  logic [IDX_W-1:0] launch_idx,
   input  logic             launch_cmd,
   input  line_t            launch_line,
   input  logic             gnt,
   output logic             req,
   output logic             cmd,
   output logic [IDX_W-1:0] idx,
   output logic             commit,
   output line_t            commit_line
);

   logic             req_q;
   logic             cmd_q;
   logic [IDX_W-1:0] idx_q;
   line_t            line_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         cmd_q  <= CMD_INVAL;
         idx_q  <= '0;
         line_q <= LN_INV;
      end else if (launch) begin
         req_q  <= 1'b1;
         cmd_q  <= launch_cmd;
         idx_q  <= launch_idx;
         line_q <= launch_line;
      end else if (req_q && gnt) begin
         req_q  <= 1'b0;
      end
   end

   assign req         = req_q;
   assign cmd         = cmd_q;
   assign idx         = idx_q;
   assign commit      = req_q && gnt;
   assign commit_line = line_q;

   AST_NO_LAUNCH_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      launch |-> !req_q); // R10

endmodule

// File: rtl/cluster_incl_ctrl.sv
module cluster_incl_ctrl
   import cic_pkg::*;
#(
   parameter int LINES = 16,
   localparam int IDX_W = $clog2(LINES)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic [3:0]       op_code,
   input  logic [IDX_W-1:0] op_idx,
   input  logic             op_excl,
   output logic             op_ready,
   output logic             l1_req,
   output logic             l1_cmd,
   output logic [IDX_W-1:0] l1_idx,
   input  logic             l1_gnt,
   input  logic [IDX_W-1:0] qry_idx,
   output logic [2:0]       qry_state
);

   generate
      if (LINES < 2)
         $error("cluster_incl_ctrl: LINES must be at least 2");
      if ((1 << IDX_W) != LINES)
         $error("cluster_incl_ctrl: LINES must be a power of two");
   endgenerate

   op_t   op;
   line_t cur_line;
   line_t nxt_line;
   line_t qry_line;
   line_t commit_line;
   line_t wr_line;
   logic  need_l1;
   logic  l1_kind;
   logic  accept;
   logic  launch;
   logic  commit;
   logic  wr_en;
   logic [IDX_W-1:0] wr_idx;

   assign op       = op_t'(op_code);
   assign op_ready = !l1_req;
   assign accept   = op_valid && op_ready;
   assign launch   = accept && need_l1;

   cic_state_store #(.LINES(LINES)) i_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_line   (wr_line),
      .rd_a_idx  (op_idx),
      .rd_a_line (cur_line),
      .rd_b_idx  (qry_idx),
      .rd_b_line (qry_line)
   );

   cic_next_state i_next (
      .cur     (cur_line),
      .op      (op),
      .excl    (op_excl),
      .nxt     (nxt_line),
      .need_l1 (need_l1),
      .l1_kind (l1_kind)
   );

   cic_l1_cmd_hold #(.LINES(LINES)) i_hold (
      .clk         (clk),
      .rst_n       (rst_n),
      .launch      (launch),
      .launch_idx  (op_idx),
      .launch_cmd  (l1_kind),
      .launch_line (nxt_line),
      .gnt         (l1_gnt),
      .req         (l1_req),
      .cmd         (l1_cmd),
      .idx         (l1_idx),
      .commit      (commit),
      .commit_line (commit_line)
   );

   always_comb begin
      if (commit) begin
         wr_en   = 1'b1;
         wr_idx  = l1_idx;
         wr_line = commit_line;
      end else begin
         wr_en   = accept && !need_l1;
         wr_idx  = op_idx;
         wr_line = nxt_line;
      end
   end

   assign qry_state = {qry_line.vld, qry_line.ib, qry_line.cd};

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (l1_req && !l1_gnt) |=> (l1_req && $stable(l1_idx) && $stable(l1_cmd))); // R10
   AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      l1_req |-> !op_ready); // R10
   AST_NO_L1_WITHOUT_IB: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !cur_line.ib) |=> !l1_req); // R8
   AST_DIRTYI_PURGES: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && cur_line == LN_DIRTY_I && is_inter(op)) |=> (l1_req && l1_cmd == CMD_PURGE)); // R7
   AST_CLEANI_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && cur_line == LN_CLEAN_I && op == OP_XRD) |=> !l1_req); // R6
   AST_WFILL_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && op == OP_WFILL && qry_idx == op_idx && $stable(qry_idx))
      |=> (qry_state == 3'b110)); // R3

endmodule

// File: tb/test_cluster_incl_ctrl.sv
module test_cluster_incl_ctrl;

   localparam int LINES = 16;
   localparam int IDX_W = 4;

   typedef struct packed {
      logic [3:0] op;
      logic [3:0] idx;
      logic       excl;
      logic       req;
      logic       cmd;
      logic [2:0] st;
      logic [3:0] rq;
   } vec_t;

   localparam int NV = 34;
   localparam vec_t VEC [NV] = '{
      '{4'd1, 4'd1, 1'b0, 1'b0, 1'b0, 3'b111, 4'd2},   // R2 fill
      '{4'd5, 4'd1, 1'b0, 1'b0, 1'b0, 3'b111, 4'd6},   // R6 read quiet
      '{4'd6, 4'd1, 1'b0, 1'b1, 1'b0, 3'b000, 4'd6},   // R6 write -> inval
      '{4'd2, 4'd2, 1'b0, 1'b0, 1'b0, 3'b110, 4'd3},   // R3
      '{4'd5, 4'd2, 1'b0, 1'b1, 1'b1, 3'b111, 4'd7},   // R7 read purge
      '{4'd4, 4'd2, 1'b0, 1'b0, 1'b0, 3'b110, 4'd4},   // R4
      '{4'd7, 4'd2, 1'b0, 1'b1, 1'b1, 3'b000, 4'd7},   // R7 inv purge
      '{4'd1, 4'd3, 1'b0, 1'b0, 1'b0, 3'b111, 4'd2},
      '{4'd3, 4'd3, 1'b1, 1'b0, 1'b0, 3'b100, 4'd5},   // R5 excl
      '{4'd5, 4'd3, 1'b0, 1'b0, 1'b0, 3'b101, 4'd8},   // R8 dirty alone read
      '{4'd5, 4'd3, 1'b0, 1'b0, 1'b0, 3'b101, 4'd8},   // R8 clean alone read
      '{4'd6, 4'd3, 1'b0, 1'b0, 1'b0, 3'b000, 4'd8},   // R8 write
      '{4'd1, 4'd4, 1'b0, 1'b0, 1'b0, 3'b111, 4'd2},
      '{4'd3, 4'd4, 1'b0, 1'b0, 1'b0, 3'b110, 4'd5},   // R5 shared wb
      '{4'd8, 4'd4, 1'b0, 1'b1, 1'b1, 3'b000, 4'd9},   // R9 purge
      '{4'd1, 4'd5, 1'b0, 1'b0, 1'b0, 3'b111, 4'd2},
      '{4'd8, 4'd5, 1'b0, 1'b1, 1'b0, 3'b000, 4'd9},   // R9 inval
      '{4'd1, 4'd6, 1'b0, 1'b0, 1'b0, 3'b111, 4'd2},
      '{4'd3, 4'd6, 1'b1, 1'b0, 1'b0, 3'b100, 4'd5},
      '{4'd8, 4'd6, 1'b0, 1'b0, 1'b0, 3'b000, 4'd9},   // R9 silent
      '{4'd3, 4'd7, 1'b1, 1'b0, 1'b0, 3'b000, 4'd5},   // R5 on invalid
      '{4'd4, 4'd7, 1'b0, 1'b0, 1'b0, 3'b000, 4'd4},   // R4 on invalid
      '{4'd7, 4'd7, 1'b0, 1'b0, 1'b0, 3'b000, 4'd8},   // R8 on invalid
      '{4'd2, 4'd8, 1'b0, 1'b0, 1'b0, 3'b110, 4'd3},
      '{4'd3, 4'd8, 1'b1, 1'b0, 1'b0, 3'b100, 4'd5},
      '{4'd1, 4'd8, 1'b0, 1'b0, 1'b0, 3'b110, 4'd2},   // R2 keeps dirty
      '{4'd1, 4'd9, 1'b0, 1'b0, 1'b0, 3'b111, 4'd2},
      '{4'd7, 4'd9, 1'b0, 1'b1, 1'b0, 3'b000, 4'd6},   // R6 invalidate op
      '{4'd2, 4'd10, 1'b0, 1'b0, 1'b0, 3'b110, 4'd3},
      '{4'd6, 4'd10, 1'b0, 1'b1, 1'b1, 3'b000, 4'd7},  // R7 write purge
      '{4'd1, 4'd12, 1'b0, 1'b0, 1'b0, 3'b111, 4'd2},
      '{4'd3, 4'd12, 1'b1, 1'b0, 1'b0, 3'b100, 4'd5},
      '{4'd5, 4'd12, 1'b0, 1'b0, 1'b0, 3'b101, 4'd8},
      '{4'd2, 4'd12, 1'b0, 1'b0, 1'b0, 3'b110, 4'd3}   // R3 from clean alone
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             op_valid = 1'b0;
   logic [3:0]       op_code = '0;
   logic [IDX_W-1:0] op_idx = '0;
   logic             op_excl = 1'b0;
   logic             op_ready;
   logic             l1_req;
   logic             l1_cmd;
   logic [IDX_W-1:0] l1_idx;
   logic             l1_gnt = 1'b0;
   logic [IDX_W-1:0] qry_idx = '0;
   logic [2:0]       qry_state;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   cluster_incl_ctrl #(.LINES(LINES)) i_cluster_incl_ctrl (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .op_idx(op_idx), .op_excl(op_excl), .op_ready(op_ready),
      .l1_req(l1_req), .l1_cmd(l1_cmd), .l1_idx(l1_idx), .l1_gnt(l1_gnt),
      .qry_idx(qry_idx), .qry_state(qry_state)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic issue(input logic [3:0] op, input logic [3:0] idx, input logic ex);
      @(negedge clk);
      op_valid = 1'b1; op_code = op; op_idx = idx; op_excl = ex;
      @(negedge clk);
      op_valid = 1'b0; op_code = '0;
   endtask

   task automatic grant();
      @(negedge clk);
      l1_gnt = 1'b1;
      @(negedge clk);
      l1_gnt = 1'b0;
   endtask

   task automatic state_is(input string tag, input logic [3:0] idx, input logic [2:0] exp);
      qry_idx = idx;
      #1;
      check(tag, int'(qry_state), int'(exp));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL R10 watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 l1_req", int'(l1_req), 0);
      check("R1 op_ready", int'(op_ready), 1);
      for (int k = 0; k < LINES; k++) state_is("R1 line", 4'(k), 3'b000);

      for (int i = 0; i < NV; i++) begin
         string tag;
         tag = $sformatf("R%0d vec%0d", VEC[i].rq, i);
         issue(VEC[i].op, VEC[i].idx, VEC[i].excl);
         check({tag, " req"}, int'(l1_req), int'(VEC[i].req));
         if (VEC[i].req) begin
            check({tag, " cmd"}, int'(l1_cmd), int'(VEC[i].cmd));
            check({tag, " idx"}, int'(l1_idx), int'(VEC[i].idx));
            for (int d = 0; d < (i % 3); d++) begin
               @(negedge clk);
               // R10 held until grant
               check({tag, " R10 hold req"}, int'(l1_req), 1);
               check({tag, " R10 hold cmd"}, int'(l1_cmd), int'(VEC[i].cmd));
               check({tag, " R10 hold idx"}, int'(l1_idx), int'(VEC[i].idx));
            end
            grant();
            check({tag, " R10 released"}, int'(l1_req), 0);
         end
         state_is({tag, " state"}, VEC[i].idx, VEC[i].st);
      end

      // R10: operation during a held command is ignored, state deferred
      issue(4'd1, 4'd13, 1'b0);
      issue(4'd6, 4'd13, 1'b0);
      check("R10 pending req", int'(l1_req), 1);
      state_is("R10 deferred state", 4'd13, 3'b111);
      @(negedge clk);
      check("R10 op_ready low", int'(op_ready), 0);
      op_valid = 1'b1; op_code = 4'd1; op_idx = 4'd14;
      @(negedge clk);
      op_valid = 1'b0; op_code = '0;
      grant();
      state_is("R10 ignored op", 4'd14, 3'b000);
      state_is("R10 committed", 4'd13, 3'b000);
      check("R10 ready again", int'(op_ready), 1);

      // R1: reset while a command is held
      issue(4'd1, 4'd15, 1'b0);
      issue(4'd7, 4'd15, 1'b0);
      check("R1 pre-reset req", int'(l1_req), 1);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset clears req", int'(l1_req), 0);
      state_is("R1 reset clears line", 4'd15, 3'b000);
      state_is("R1 reset clears other", 4'd12, 3'b000);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule